// File: doc/BRIEF.md
# Logic analyzer command decoder

This block sits between a byte-wide receive stream from a host serial link and the configuration registers of a logic analyzer. It splits incoming bytes into commands. An opcode with bit 7 clear is a one-byte command. An opcode with bit 7 set is followed by four argument bytes, sent least significant byte first.

Long commands load the configuration registers:
- the per-stage trigger mask, value, configuration and edge words,
- the 24-bit sample clock divider,
- the 32-bit read and delay counts, each holding the wanted count minus one,
- the 16-bit flag word.

Short commands do one of four things: start a capture with a one-cycle arm pulse, return every register to zero, return the 4-byte identification reply, or return an 11-byte description reply. Reset is a single-byte opcode and repeating it does no harm. A host that has lost track sends it five times. The first four copies fill out any half-received long command, and the fifth is decoded as a reset from the opcode position.

Both byte streams use valid/ready. A receive byte is taken on a clock edge where `rx_valid` and `rx_ready` are both high. The decoder drops `rx_ready` for the cycle after a command completes, and for as long as a reply is queued. A reply byte leaves on an edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold.

Top module: `la_cmd_decoder`

## Requirements
- R1: A received opcode byte with bit 7 set starts a long command that takes exactly four more bytes. An opcode byte with bit 7 clear is a complete command by itself.
- R2: Opcode 0x81 loads `read_count` and opcode 0x82 loads `delay_count`, each with the full 32-bit argument. Argument byte 0, the first byte sent after the opcode, lands in bits 7:0.
- R3: Opcode 0x80 loads `clk_div` from argument bytes 0 to 2. Byte 0 goes to bits 7:0 and byte 2 to bits 23:16. Byte 3 has no effect.
- R4: Opcode 0x83 loads `flags` from argument bytes 0 and 1, with byte 0 in bits 7:0. Bytes 2 and 3 have no effect.
- R5: For stage n < NSTAGES, opcode 0xC0+4n loads that stage's mask, 0xC1+4n its value, 0xC2+4n its configuration word and 0xC3+4n its edge word. Stage n occupies bits 32n+31:32n of the matching flattened output. No other stage or register changes.
- R6: Opcode 0x01 drives `arm_pulse` high for exactly one cycle. That cycle starts at the second rising edge after the edge that accepts the opcode.
- R7: Opcode 0x00, received at the opcode position, sets every configuration register to zero and pulses `soft_rst` for one cycle, in the same cycle that `arm_pulse` would take.
- R8: From any byte position within a long command, five consecutive 0x00 bytes leave all registers at zero, with the parser back at the opcode position.
- R9: Opcode 0x02 queues the 4-byte reply 0x31, 0x53, 0x4C, 0x4F, in that order.
- R10: Opcode 0x04 queues an 11-byte reply, in this order:
  - the byte 0x20,
  - MEM_BYTES as 4 bytes, most significant first,
  - the byte 0x23,
  - RATE_HZ as 4 bytes, most significant first,
  - the byte 0x00.
- R11: While `tx_valid` is high and `tx_ready` low, `tx_valid` and `tx_data` hold. `rx_ready` is low while a reply byte is pending.
- R12: The following have no effect on any register and produce no reply and no pulse:
  - short opcodes other than 0x00, 0x01, 0x02 and 0x04,
  - long opcodes 0x84 to 0xBF,
  - trigger opcodes whose stage field, bits 5:2, is at least NSTAGES.
- R13: A register written by a long command shows its new value from the second rising edge after the edge that accepts the last argument byte. Before that edge it still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Decoder accepts a receive byte |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Host link takes the reply byte |
| tx_data | output | 8 | Reply byte |
| arm_pulse | output | 1 | One-cycle capture start |
| soft_rst | output | 1 | One-cycle pulse on reset opcode |
| clk_div | output | 24 | Sample clock divider |
| read_count | output | 32 | Read count minus one |
| delay_count | output | 32 | Delay count minus one |
| flags | output | 16 | Flag word |
| trig_mask | output | 32*NSTAGES | Trigger masks, stage n at bits 32n+31:32n |
| trig_value | output | 32*NSTAGES | Trigger values |
| trig_cfg | output | 32*NSTAGES | Trigger configuration words |
| trig_edge | output | 32*NSTAGES | Trigger edge words |

## Verification
- **Stage and kind sweep.** A distinct argument is written for every stage and every kind. This shows whether the stage and kind decode is wrong or leaks into a neighbouring stage, because every register is compared against a model after each write.
- **Byte-order arguments.** The divider, flag and count writes use arguments whose four bytes all differ. This separates byte ordering errors from truncation errors on the ignored high bytes.
- **Five-reset recovery.** The reset sequence starts from each of the five byte positions inside a long command, and a divider write follows to confirm realignment.
- **Replies and undefined opcodes.** Both replies are drained with and without back-pressure stalls. Undefined short, long and out-of-range stage opcodes are checked for leaving all outputs untouched.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam logic [7:0] OP_RESET  = 8'h00;
  localparam logic [7:0] OP_RUN    = 8'h01;
  localparam logic [7:0] OP_ID     = 8'h02;
  localparam logic [7:0] OP_META   = 8'h04;
  localparam logic [7:0] OP_DIV    = 8'h80;
  localparam logic [7:0] OP_RDCNT  = 8'h81;
  localparam logic [7:0] OP_DLYCNT = 8'h82;
  localparam logic [7:0] OP_FLAGS  = 8'h83;
  localparam int ARG_BYTES = 4;
  localparam int ARG_W     = 8 * ARG_BYTES;

  typedef enum logic [1:0] {RP_NONE, RP_ID, RP_META} reply_e;

  typedef struct packed {
    logic             is_long;
    logic [7:0]       op;
    logic [ARG_W-1:0] arg;
  } cmd_t;
endpackage

// File: rtl/la_cmd_parser.sv
module la_cmd_parser
  import la_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_stb,
  input  logic [7:0] byte_in,
  output logic       cmd_stb,
  output cmd_t       cmd
);
  localparam int POS_W = $clog2(ARG_BYTES + 1);

  logic [POS_W-1:0] pos;
  logic [7:0]       op_q;
  logic [ARG_W-1:0] arg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      op_q    <= '0;
      arg_q   <= '0;
      cmd_stb <= 1'b0;
      cmd     <= '0;
    end else begin
      cmd_stb <= 1'b0;
      if (byte_stb) begin
        if (pos == '0) begin
          if (byte_in[7]) begin
            op_q <= byte_in;
            pos  <= POS_W'(1);
          end else begin
            cmd_stb <= 1'b1;
            cmd     <= '{is_long: 1'b0, op: byte_in, arg: '0};
          end
        end else begin
          arg_q <= {byte_in, arg_q[ARG_W-1:8]};
          if (pos == POS_W'(ARG_BYTES)) begin
            cmd_stb <= 1'b1;
            cmd     <= '{is_long: 1'b1, op: op_q, arg: {byte_in, arg_q[ARG_W-1:8]}};
            pos     <= '0;
          end else begin
            pos <= pos + POS_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/la_cmd_regs.sv
module la_cmd_regs
  import la_cmd_pkg::*;
#(
  parameter int NSTAGES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_stb,
  input  cmd_t                 cmd,
  output logic                 arm_pulse,
  output logic                 soft_rst,
  output logic [23:0]          clk_div,
  output logic [31:0]          read_count,
  output logic [31:0]          delay_count,
  output logic [15:0]          flags,
  output logic [32*NSTAGES-1:0] trig_mask,
  output logic [32*NSTAGES-1:0] trig_value,
  output logic [32*NSTAGES-1:0] trig_cfg,
  output logic [32*NSTAGES-1:0] trig_edge
);
  logic short_hit, long_hit, clr;
  assign short_hit = cmd_stb && !cmd.is_long;
  assign long_hit  = cmd_stb && cmd.is_long;
  assign clr       = short_hit && cmd.op == OP_RESET;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_pulse   <= 1'b0;
      soft_rst    <= 1'b0;
      clk_div     <= '0;
      read_count  <= '0;
      delay_count <= '0;
      flags       <= '0;
    end else begin
      arm_pulse <= short_hit && cmd.op == OP_RUN;
      soft_rst  <= clr;
      if (clr) begin
        clk_div     <= '0;
        read_count  <= '0;
        delay_count <= '0;
        flags       <= '0;
      end else if (long_hit) begin
        case (cmd.op)
          OP_DIV:    clk_div     <= cmd.arg[23:0];
          OP_RDCNT:  read_count  <= cmd.arg;
          OP_DLYCNT: delay_count <= cmd.arg;
          OP_FLAGS:  flags       <= cmd.arg[15:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NSTAGES; g++) begin : g_stage
    logic hit;
    assign hit = long_hit && cmd.op[7:6] == 2'b11 && cmd.op[5:2] == 4'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_mask[32*g +: 32]  <= '0;
        trig_value[32*g +: 32] <= '0;
        trig_cfg[32*g +: 32]   <= '0;
        trig_edge[32*g +: 32]  <= '0;
      end else if (clr) begin
        trig_mask[32*g +: 32]  <= '0;
        trig_value[32*g +: 32] <= '0;
        trig_cfg[32*g +: 32]   <= '0;
        trig_edge[32*g +: 32]  <= '0;
      end else if (hit) begin
        case (cmd.op[1:0])
          2'd0: trig_mask[32*g +: 32]  <= cmd.arg;
          2'd1: trig_value[32*g +: 32] <= cmd.arg;
          2'd2: trig_cfg[32*g +: 32]   <= cmd.arg;
          default: trig_edge[32*g +: 32] <= cmd.arg;
        endcase
      end
    end
  end
endmodule

// File: rtl/la_cmd_reply.sv
module la_cmd_reply
  import la_cmd_pkg::*;
#(
  parameter logic [31:0] MEM_BYTES = 32'd65536,
  parameter logic [31:0] RATE_HZ   = 32'd200000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_id,
  input  logic       start_meta,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  localparam int ID_LEN   = 4;
  localparam int META_LEN = 11;
  localparam int IDX_W    = $clog2(META_LEN);

  reply_e           kind;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last;

  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] i);
    case (i)
      IDX_W'(0): return 8'h31;
      IDX_W'(1): return 8'h53;
      IDX_W'(2): return 8'h4C;
      default:   return 8'h4F;
    endcase
  endfunction

  function automatic logic [7:0] meta_byte(input logic [IDX_W-1:0] i);
    case (i)
      IDX_W'(0): return 8'h20;
      IDX_W'(1): return MEM_BYTES[31:24];
      IDX_W'(2): return MEM_BYTES[23:16];
      IDX_W'(3): return MEM_BYTES[15:8];
      IDX_W'(4): return MEM_BYTES[7:0];
      IDX_W'(5): return 8'h23;
      IDX_W'(6): return RATE_HZ[31:24];
      IDX_W'(7): return RATE_HZ[23:16];
      IDX_W'(8): return RATE_HZ[15:8];
      IDX_W'(9): return RATE_HZ[7:0];
      default:   return 8'h00;
    endcase
  endfunction

  assign tx_valid = kind != RP_NONE;
  assign last     = (kind == RP_ID) ? IDX_W'(ID_LEN - 1) : IDX_W'(META_LEN - 1);

  always_comb begin
    tx_data = 8'h00;
    if (kind == RP_ID)        tx_data = id_byte(idx);
    else if (kind == RP_META) tx_data = meta_byte(idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= RP_NONE;
      idx  <= '0;
    end else if (kind == RP_NONE) begin
      idx <= '0;
      if (start_id)        kind <= RP_ID;
      else if (start_meta) kind <= RP_META;
    end else if (tx_ready) begin
      if (idx == last) begin
        kind <= RP_NONE;
        idx  <= '0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
  import la_cmd_pkg::*;
#(
  parameter int          NSTAGES   = 4,
  parameter logic [31:0] MEM_BYTES = 32'd65536,
  parameter logic [31:0] RATE_HZ   = 32'd200000000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  input  logic [7:0]            rx_data,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [7:0]            tx_data,
  output logic                  arm_pulse,
  output logic                  soft_rst,
  output logic [23:0]           clk_div,
  output logic [31:0]           read_count,
  output logic [31:0]           delay_count,
  output logic [15:0]           flags,
  output logic [32*NSTAGES-1:0] trig_mask,
  output logic [32*NSTAGES-1:0] trig_value,
  output logic [32*NSTAGES-1:0] trig_cfg,
  output logic [32*NSTAGES-1:0] trig_edge
);
  logic cmd_stb;
  cmd_t cmd;
  logic byte_stb, start_id, start_meta;

  assign rx_ready   = !tx_valid && !cmd_stb;
  assign byte_stb   = rx_valid && rx_ready;
  assign start_id   = cmd_stb && !cmd.is_long && cmd.op == OP_ID;
  assign start_meta = cmd_stb && !cmd.is_long && cmd.op == OP_META;

  la_cmd_parser u_parser (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_in(rx_data),
    .cmd_stb(cmd_stb), .cmd(cmd)
  );

  la_cmd_regs #(.NSTAGES(NSTAGES)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd(cmd),
    .arm_pulse(arm_pulse), .soft_rst(soft_rst), .clk_div(clk_div),
    .read_count(read_count), .delay_count(delay_count), .flags(flags),
    .trig_mask(trig_mask), .trig_value(trig_value),
    .trig_cfg(trig_cfg), .trig_edge(trig_edge)
  );

  la_cmd_reply #(.MEM_BYTES(MEM_BYTES), .RATE_HZ(RATE_HZ)) u_reply (
    .clk(clk), .rst_n(rst_n), .start_id(start_id), .start_meta(start_meta),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );
endmodule

// File: rtl/la_cmd_checker.sv
module la_cmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        arm_pulse,
  input logic        soft_rst,
  input logic [23:0] clk_div,
  input logic [31:0] read_count,
  input logic [31:0] delay_count,
  input logic [15:0] flags
);
  p_arm_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_pulse |=> !arm_pulse);

  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_pulse && soft_rst));

  p_reset_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (clk_div == '0 && read_count == '0 && delay_count == '0 && flags == '0));

  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_rx_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
endmodule

bind la_cmd_decoder la_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .arm_pulse(arm_pulse),
  .soft_rst(soft_rst), .clk_div(clk_div), .read_count(read_count),
  .delay_count(delay_count), .flags(flags)
);

// File: tb/la_cmd_decoder_test.sv
module la_cmd_decoder_test;
  localparam int NS = 4;
  localparam logic [31:0] MEMB = 32'd65536;
  localparam logic [31:0] RATE = 32'd200000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_ready = 1'b0;
  logic rx_ready, tx_valid, arm_pulse, soft_rst;
  logic [7:0] tx_data;
  logic [23:0] clk_div;
  logic [31:0] read_count, delay_count;
  logic [15:0] flags;
  logic [32*NS-1:0] trig_mask, trig_value, trig_cfg, trig_edge;

  int checks = 0;
  int fails = 0;

  logic [31:0] m_trig [4][NS];
  logic [23:0] m_div;
  logic [31:0] m_rd, m_dly;
  logic [15:0] m_flags;
  logic [7:0]  exp_b [11];

  always #2 clk = ~clk;

  la_cmd_decoder #(.NSTAGES(NS), .MEM_BYTES(MEMB), .RATE_HZ(RATE)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .arm_pulse(arm_pulse), .soft_rst(soft_rst),
    .clk_div(clk_div), .read_count(read_count), .delay_count(delay_count),
    .flags(flags), .trig_mask(trig_mask), .trig_value(trig_value),
    .trig_cfg(trig_cfg), .trig_edge(trig_edge)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < NS; s++) m_trig[k][s] = '0;
    m_div = '0; m_rd = '0; m_dly = '0; m_flags = '0;
  endtask

  task automatic check_all(input string tag);
    logic [32*NS-1:0] v;
    for (int k = 0; k < 4; k++) begin
      v = (k == 0) ? trig_mask : (k == 1) ? trig_value : (k == 2) ? trig_cfg : trig_edge;
      for (int s = 0; s < NS; s++)
        check($sformatf("%s trig k%0d s%0d", tag, k, s), v[32*s +: 32], m_trig[k][s]);
    end
    check({tag, " clk_div"}, {8'h0, clk_div}, {8'h0, m_div});
    check({tag, " read_count"}, read_count, m_rd);
    check({tag, " delay_count"}, delay_count, m_dly);
    check({tag, " flags"}, {16'h0, flags}, {16'h0, m_flags});
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
    send_byte(op);
    for (int i = 0; i < 4; i++) send_byte(arg[8*i +: 8]);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(input string tag, input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      while (!tx_valid && w < 10) begin @(negedge clk); w++; end
      check($sformatf("%s byte %0d", tag, i), {24'h0, tx_data}, {24'h0, exp_b[i]});
      check({tag, " R11 rx_ready low"}, {31'h0, rx_ready}, 32'h0);
      if (stall && (i % 2 == 0)) begin
        @(negedge clk);
        check({tag, " R11 hold"}, {23'h0, tx_valid, tx_data}, {23'h0, 1'b1, exp_b[i]});
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    check({tag, " end of reply"}, {31'h0, tx_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] a;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("reset R7");
    check("reset tx_valid", {31'h0, tx_valid}, 32'h0);
    check("reset rx_ready", {31'h0, rx_ready}, 32'h1);

    // R5: sweep every stage and kind
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++) begin
        a = {4'(s), 4'(k), 8'h5A ^ 8'(s * 16 + k), 16'hC3A5 + 16'(s * 4 + k)};
        send_long(8'hC0 + 8'(4 * s + k), a);
        settle();
        m_trig[k][s] = a;
        check_all($sformatf("R5 stage%0d kind%0d", s, k));
      end

    // R3, R13: divider byte order and latency
    send_long(8'h80, 32'hDDCCBBAA);
    check("R13 old value before edge", {8'h0, clk_div}, 32'h0);
    @(negedge clk);
    check("R13 new value after edge", {8'h0, clk_div}, 32'h00CCBBAA);
    m_div = 24'hCCBBAA;
    @(negedge clk);
    check_all("R3 divider");

    // R4: flags
    send_long(8'h83, 32'h44332211);
    settle();
    m_flags = 16'h2211;
    check_all("R4 flags");

    // R2, R1: counts
    send_long(8'h81, 32'h87654321);
    settle();
    m_rd = 32'h87654321;
    send_long(8'h82, 32'h0F1E2D3C);
    settle();
    m_dly = 32'h0F1E2D3C;
    check_all("R2 R1 counts");

    // R12: undefined opcodes
    send_byte(8'h03);
    send_byte(8'h7F);
    send_long(8'h84, 32'hFFFFFFFF);
    send_long(8'hBF, 32'hFFFFFFFF);
    send_long(8'hC0 + 8'(4 * NS), 32'hFFFFFFFF);
    settle();
    check_all("R12 ignored");
    check("R12 no reply", {30'h0, tx_valid, arm_pulse}, 32'h0);

    // R6: arm pulse timing
    send_byte(8'h01);
    check("R6 arm before", {31'h0, arm_pulse}, 32'h0);
    @(negedge clk);
    check("R6 arm high", {31'h0, arm_pulse}, 32'h1);
    @(negedge clk);
    check("R6 arm one cycle", {31'h0, arm_pulse}, 32'h0);
    check_all("R6 regs kept");

    // R9, R11: ID reply
    exp_b[0] = 8'h31; exp_b[1] = 8'h53; exp_b[2] = 8'h4C; exp_b[3] = 8'h4F;
    send_byte(8'h02);
    drain("R9 id", 4, 1'b0);
    send_byte(8'h02);
    drain("R9 id stalled", 4, 1'b1);

    // R10: description reply
    exp_b[0] = 8'h20;
    for (int i = 0; i < 4; i++) exp_b[1 + i] = MEMB[31 - 8*i -: 8];
    exp_b[5] = 8'h23;
    for (int i = 0; i < 4; i++) exp_b[6 + i] = RATE[31 - 8*i -: 8];
    exp_b[10] = 8'h00;
    send_byte(8'h04);
    drain("R10 meta", 11, 1'b1);
    check_all("R10 regs kept");

    // R7: reset opcode
    send_byte(8'h00);
    @(negedge clk);
    check("R7 soft_rst pulse", {31'h0, soft_rst}, 32'h1);
    model_clear();
    check_all("R7 cleared");

    // R8: five resets from every byte position
    for (int p = 0; p <= 4; p++) begin
      send_long(8'h80, 32'h00123456);
      send_long(8'h83, 32'h0000BEEF);
      send_byte(8'h81);
      for (int i = 0; i < p - 1; i++) send_byte(8'hA0 + 8'(i));
      if (p == 0) begin
        // p=0: parser sits at the opcode position after the full long command
        for (int i = 0; i < 4; i++) send_byte(8'h11);
      end
      for (int i = 0; i < 5; i++) send_byte(8'h00);
      settle();
      model_clear();
      check_all($sformatf("R8 pos%0d cleared", p));
      send_long(8'h80, 32'h00ABCDEF);
      settle();
      m_div = 24'hABCDEF;
      check_all($sformatf("R8 pos%0d realigned", p));
      send_byte(8'h00);
      settle();
      model_clear();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule